// File: doc/BRIEF.md
# 4x4 Integer Tile Multiply-Accumulate Unit

This datapath block takes two 4x4 tiles of signed 8-bit operands, A and B, and a 4x4 tile of signed 32-bit accumulators, C. It produces D = A·B + C as one operation. Every output cell adds the four products of its row of A and its column of B to its C entry, so each operation covers all 64 multiply-adds of the tile.

The unit is a two-stage pipeline. Stage one registers all 64 products. Stage two sums the products of each cell together with the matching C entry and registers D. There is no stall input. A new tile operation may be issued on every clock, and each result appears a fixed two cycles after it was issued. All tiles travel on flattened row-major buses. A tiling controller uses the block by feeding the D of one step back as the C of the next.

Top module: `tile_mac`

## Requirements
- R1: D[i][j] equals C[i][j] plus the sum over k of A[i][k]·B[k][j]. A and B entries are 8-bit two's-complement values. C and D entries are 32-bit two's-complement values.
- R2: Each tile bus is row-major. Entry (row r, column c) sits at bits [(r*4+c)*W +: W], where W is 8 for a_i and b_i and 32 for c_i and d_o.
- R3: The sum wraps modulo 2^32. For example, a C entry of 0x7FFFFFFF plus four unit products gives 0x80000003.
- R4: valid_o is high in exactly the cycles that follow, by two clock edges, an edge at which valid_i was sampled high. d_o carries that operation's result in the same cycle.
- R5: Operations issued on consecutive cycles each give their own result, in issue order, with no gap and no interference.
- R6: d_o keeps its last result while valid_o is low. Tile inputs presented with valid_i low have no effect on d_o.
- R7: An all-zero A tile or an all-zero B tile yields D equal to C.
- R8: While rst_ni is low, valid_o is 0 and d_o is all zeros.
- R9: Extreme operands are exact. A = B = all -128 gives 65536 in every cell. A = all -128 with B = all 127 gives -65024 in every cell.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Issue a tile operation this cycle |
| a_i | input | 128 | Operand tile A, 16 x 8-bit signed, row-major |
| b_i | input | 128 | Operand tile B, 16 x 8-bit signed, row-major |
| c_i | input | 512 | Accumulator tile C, 16 x 32-bit signed, row-major |
| valid_o | output | 1 | Result on d_o is new this cycle |
| d_o | output | 512 | Result tile D, 16 x 32-bit signed, row-major |

## Verification
Each pattern is chosen to expose a different class of fault.
- An identity A against an arbitrary B checks routing only: any crossed row or column shows up at once.
- A single nonzero entry in each of A and B must light exactly one output cell, which pins down the bit layout of the buses.
- Hashed operand tiles issued back to back expose latency and ordering faults, and catch a wrong sign extension.
- All-minus-128 tiles, a near-overflow C and zero A or zero B tiles probe the extremes, the wrap and the accumulator pass-through.
- Idle cycles carrying garbage operands show whether d_o is disturbed by inputs that were never issued.

// File: rtl/tile_mac_pkg.sv
package tile_mac_pkg;
  localparam int unsigned TILE_N_DEF = 4;
  localparam int unsigned OPND_W_DEF = 8;
  localparam int unsigned ACC_W_DEF  = 32;

  // row-major cell index
  function automatic int unsigned cell_idx(int unsigned r, int unsigned c, int unsigned n);
    return r * n + c;
  endfunction
endpackage

// File: rtl/tile_mac_mul.sv
module tile_mac_mul #(
  parameter int unsigned N      = 4,
  parameter int unsigned OPND_W = 8,
  parameter int unsigned ACC_W  = 32,
  localparam int unsigned PROD_W = 2 * OPND_W,
  localparam int unsigned CELLS  = N * N
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        valid_i,
  input  logic [CELLS*OPND_W-1:0]     a_i,
  input  logic [CELLS*OPND_W-1:0]     b_i,
  input  logic [CELLS*ACC_W-1:0]      c_i,
  output logic                        valid_o,
  output logic [CELLS*N*PROD_W-1:0]   prod_o,
  output logic [CELLS*ACC_W-1:0]      c_o
);
  import tile_mac_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      c_o     <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) c_o <= c_i;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      for (genvar k = 0; k < N; k++) begin : g_k
        localparam int unsigned AI = cell_idx(i, k, N);
        localparam int unsigned BI = cell_idx(k, j, N);
        localparam int unsigned PI = cell_idx(i, j, N) * N + k;
        logic signed [OPND_W-1:0] av, bv;
        logic signed [PROD_W-1:0] prod_q;
        assign av = a_i[AI*OPND_W +: OPND_W];
        assign bv = b_i[BI*OPND_W +: OPND_W];
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni)      prod_q <= '0;
          else if (valid_i) prod_q <= PROD_W'(av) * PROD_W'(bv);
        end
        assign prod_o[PI*PROD_W +: PROD_W] = prod_q;
      end
    end
  end
endmodule

// File: rtl/tile_mac_sum.sv
module tile_mac_sum #(
  parameter int unsigned N      = 4,
  parameter int unsigned OPND_W = 8,
  parameter int unsigned ACC_W  = 32,
  localparam int unsigned PROD_W = 2 * OPND_W,
  localparam int unsigned CELLS  = N * N
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        valid_i,
  input  logic [CELLS*N*PROD_W-1:0]   prod_i,
  input  logic [CELLS*ACC_W-1:0]      c_i,
  output logic                        valid_o,
  output logic [CELLS*ACC_W-1:0]      d_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= valid_i;
  end

  for (genvar c = 0; c < CELLS; c++) begin : g_cell
    logic signed [ACC_W-1:0] cell_sum;
    logic signed [ACC_W-1:0] d_q;
    always_comb begin
      cell_sum = $signed(c_i[c*ACC_W +: ACC_W]);
      for (int k = 0; k < N; k++) begin
        cell_sum = cell_sum
                 + ACC_W'($signed(prod_i[(c*N+k)*PROD_W +: PROD_W]));
      end
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      d_q <= '0;
      else if (valid_i) d_q <= cell_sum;
    end
    assign d_o[c*ACC_W +: ACC_W] = d_q;
  end
endmodule

// File: rtl/tile_mac.sv
module tile_mac
  import tile_mac_pkg::*;
#(
  parameter int unsigned N      = TILE_N_DEF,
  parameter int unsigned OPND_W = OPND_W_DEF,
  parameter int unsigned ACC_W  = ACC_W_DEF,
  localparam int unsigned PROD_W = 2 * OPND_W,
  localparam int unsigned CELLS  = N * N
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [CELLS*OPND_W-1:0] a_i,
  input  logic [CELLS*OPND_W-1:0] b_i,
  input  logic [CELLS*ACC_W-1:0]  c_i,
  output logic                    valid_o,
  output logic [CELLS*ACC_W-1:0]  d_o
);
  logic                      s1_valid;
  logic [CELLS*N*PROD_W-1:0] s1_prod;
  logic [CELLS*ACC_W-1:0]    s1_c;

  tile_mac_mul #(.N(N), .OPND_W(OPND_W), .ACC_W(ACC_W)) u_mul (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .c_i     (c_i),
    .valid_o (s1_valid),
    .prod_o  (s1_prod),
    .c_o     (s1_c)
  );

  tile_mac_sum #(.N(N), .OPND_W(OPND_W), .ACC_W(ACC_W)) u_sum (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (s1_valid),
    .prod_i  (s1_prod),
    .c_i     (s1_c),
    .valid_o (valid_o),
    .d_o     (d_o)
  );
endmodule

// File: rtl/tile_mac_chk.sv
module tile_mac_chk #(
  parameter int unsigned N      = 4,
  parameter int unsigned OPND_W = 8,
  parameter int unsigned ACC_W  = 32,
  localparam int unsigned CELLS = N * N
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    valid_i,
  input logic [CELLS*OPND_W-1:0] a_i,
  input logic [CELLS*OPND_W-1:0] b_i,
  input logic [CELLS*ACC_W-1:0]  c_i,
  input logic                    valid_o,
  input logic [CELLS*ACC_W-1:0]  d_o
);
  logic                    vin_d1, vin_d2, zero_d1, zero_d2;
  logic [CELLS*ACC_W-1:0]  c_d1, c_d2;
  logic signed [ACC_W-1:0] ref00, ref_d1, ref_d2;

  // independent model of cell (0,0)
  always_comb begin
    logic signed [OPND_W-1:0] av, bv;
    ref00 = $signed(c_i[ACC_W-1:0]);
    for (int k = 0; k < N; k++) begin
      av = a_i[k*OPND_W +: OPND_W];
      bv = b_i[k*N*OPND_W +: OPND_W];
      ref00 = ref00 + ACC_W'(av) * ACC_W'(bv);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vin_d1 <= 1'b0; vin_d2 <= 1'b0;
      zero_d1 <= 1'b0; zero_d2 <= 1'b0;
      c_d1 <= '0; c_d2 <= '0;
      ref_d1 <= '0; ref_d2 <= '0;
    end else begin
      vin_d1  <= valid_i;               vin_d2  <= vin_d1;
      zero_d1 <= (a_i == '0) || (b_i == '0); zero_d2 <= zero_d1;
      c_d1    <= c_i;                   c_d2    <= c_d1;
      ref_d1  <= ref00;                 ref_d2  <= ref_d1;
    end
  end

  p_latency_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == vin_d2);

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vin_d1 |=> $stable(d_o));

  p_zero_pass_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vin_d2 && zero_d2) |-> d_o == c_d2);

  p_cell00_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vin_d2 |-> $signed(d_o[ACC_W-1:0]) == ref_d2);
endmodule

bind tile_mac tile_mac_chk #(.N(N), .OPND_W(OPND_W), .ACC_W(ACC_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .a_i     (a_i),
  .b_i     (b_i),
  .c_i     (c_i),
  .valid_o (valid_o),
  .d_o     (d_o)
);

// File: tb/tile_mac_tb_top.sv
`timescale 1ns/1ps
module tile_mac_tb_top;
  localparam int N = 4, OW = 8, AW = 32, CELLS = 16;
  localparam int AB_W = CELLS*OW, C_W = CELLS*AW;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            valid_i = 1'b0;
  logic [AB_W-1:0] a_i = '0, b_i = '0;
  logic [C_W-1:0]  c_i = '0;
  logic            valid_o;
  logic [C_W-1:0]  d_o;

  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [C_W-1:0] exp_q[$];
  string          tag_q[$];
  logic [1:0]     vsh;
  logic [C_W-1:0] last_d = '0;

  always #2.5 clk = ~clk;

  tile_mac dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i),
    .a_i(a_i), .b_i(b_i), .c_i(c_i),
    .valid_o(valid_o), .d_o(d_o)
  );

  task automatic check(bit ok, string tag, logic [C_W-1:0] act, logic [C_W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // sequential scalar accumulation, order k = 0..3
  function automatic logic [C_W-1:0] model(logic [AB_W-1:0] a, logic [AB_W-1:0] b, logic [C_W-1:0] c);
    logic [C_W-1:0] d;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        logic signed [AW-1:0] acc;
        acc = c[(i*N+j)*AW +: AW];
        for (int k = 0; k < N; k++) begin
          logic signed [OW-1:0] av, bv;
          av = a[(i*N+k)*OW +: OW];
          bv = b[(k*N+j)*OW +: OW];
          acc = acc + AW'(av) * AW'(bv);
        end
        d[(i*N+j)*AW +: AW] = acc;
      end
    return d;
  endfunction

  function automatic logic [AB_W-1:0] hash_ab(int seed);
    logic [AB_W-1:0] v;
    for (int e = 0; e < CELLS; e++) v[e*OW +: OW] = 8'((seed*73 + e*151 + 29) ^ (seed >> 2));
    return v;
  endfunction

  function automatic logic [C_W-1:0] hash_c(int seed);
    logic [C_W-1:0] v;
    for (int e = 0; e < CELLS; e++) v[e*AW +: AW] = 32'((seed*1103515245) + e*12345 - 7000);
    return v;
  endfunction

  function automatic logic [AB_W-1:0] fill_ab(logic [OW-1:0] x);
    logic [AB_W-1:0] v;
    for (int e = 0; e < CELLS; e++) v[e*OW +: OW] = x;
    return v;
  endfunction

  function automatic logic [C_W-1:0] fill_c(logic [AW-1:0] x);
    logic [C_W-1:0] v;
    for (int e = 0; e < CELLS; e++) v[e*AW +: AW] = x;
    return v;
  endfunction

  task automatic issue(logic [AB_W-1:0] a, logic [AB_W-1:0] b, logic [C_W-1:0] c, string tag);
    @(negedge clk);
    valid_i = 1'b1; a_i = a; b_i = b; c_i = c;
    exp_q.push_back(model(a, b, c));
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n, int seed);
    for (int t = 0; t < n; t++) begin
      @(negedge clk);
      valid_i = 1'b0;
      a_i = hash_ab(seed + t); b_i = hash_ab(seed + t + 9); c_i = hash_c(seed + t);
    end
  endtask

  always @(posedge clk or negedge rst_ni)
    if (!rst_ni) vsh <= '0;
    else         vsh <= {vsh[0], valid_i};

  // monitor
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      check(valid_o == vsh[1], "R4 valid_o timing", C_W'(valid_o), C_W'(vsh[1]));
      if (valid_o) begin
        if (exp_q.size() == 0) check(1'b0, "R5 unexpected result", d_o, '0);
        else begin
          logic [C_W-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(d_o === e, t, d_o, e);
        end
        last_d = d_o;
      end else begin
        check(d_o === last_d, "R6 hold", d_o, last_d);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      bad++; total++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [AB_W-1:0] id, sa, sb;
    // R8 reset state
    a_i = hash_ab(3); b_i = hash_ab(4); c_i = hash_c(5); valid_i = 1'b1;
    repeat (3) @(negedge clk);
    check(valid_o == 1'b0, "R8 reset valid_o", C_W'(valid_o), '0);
    check(d_o == '0, "R8 reset d_o", d_o, '0);
    valid_i = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    idle(2, 100);

    // R1 identity A routes B through
    id = '0;
    for (int d = 0; d < N; d++) id[(d*N+d)*OW +: OW] = 8'd1;
    issue(id, hash_ab(7), '0, "R1 identity");
    issue(hash_ab(8), id, hash_c(2), "R1 identity B plus C");
    // R2 single entries: A(1,2)=3, B(2,3)=5 -> only D(1,3)=15
    sa = '0; sa[(1*N+2)*OW +: OW] = 8'd3;
    sb = '0; sb[(2*N+3)*OW +: OW] = 8'd5;
    issue(sa, sb, '0, "R2 layout");
    // R5 back-to-back hashed tiles
    for (int s = 0; s < 20; s++) issue(hash_ab(s*3+1), hash_ab(s*5+2), hash_c(s), "R5 back-to-back");
    // R7 zero operands
    issue('0, hash_ab(11), hash_c(12), "R7 zero A");
    issue(hash_ab(13), '0, hash_c(14), "R7 zero B");
    // R9 extremes
    issue(fill_ab(8'h80), fill_ab(8'h80), '0, "R9 min*min");
    issue(fill_ab(8'h80), fill_ab(8'h7f), '0, "R9 min*max");
    // R3 wrap
    issue(fill_ab(8'd1), fill_ab(8'd1), fill_c(32'h7fff_ffff), "R3 wrap");
    issue(fill_ab(8'hff), fill_ab(8'd1), fill_c(32'h8000_0000), "R3 wrap negative");
    // R6 garbage with valid low
    idle(6, 500);
    issue(hash_ab(40), hash_ab(41), hash_c(42), "R1 after idle");
    idle(1, 600);
    issue(hash_ab(43), hash_ab(44), hash_c(45), "R1 gapped");
    idle(6, 700);

    check(exp_q.size() == 0, "R5 all results seen", C_W'(exp_q.size()), '0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule